// File: doc/BRIEF.md
# Floppy Controller Rate, Precompensation and Power Control

This block holds the host-programmed settings that pace a floppy-disk controller core. It listens on a byte-wide bus with chip select, read and write strobes and a 3-bit offset. A write to the rate/power register at offset 4 sets the transfer rate, the write-precompensation code and the manual power-down request, and can fire a self-clearing soft reset. A second register at offset 7, the configuration control register, also carries a rate field. Whichever of the two registers was written last sets the rate the core uses.

Manual low-power mode starts on a write that sets the power bit. It ends on a soft reset or on any access to the data register (offset 5, read or write) or the status register (a read at offset 4). While the mode is active, the clock enable and the data-separator enable are both low. The block also keeps the track number at which precompensation begins. That number is zero after a hardware reset and is replaced when the configure command loads a new one.

All state updates on the clock edge that samples a qualifying strobe, so outputs change one cycle after the access.

Top module: `fdc_rate_ctl`

## Requirements
- R1: After hardware reset, rate_sel is 2'b10 (250 Kbps), precomp_sel is 0, low_power and soft_rst are 0, clk_en and dsep_en are 1, and precomp_trk is 0.
- R2: A write (bus_cs and bus_wr) at offset 4 loads rate_sel from data bits 1:0 and precomp_sel from data bits 4:2 on the next cycle. The rate codes are 00 = 500 Kbps, 01 = 300 Kbps, 10 = 250 Kbps and 11 = 1 Mbps.
- R3: A write at offset 7 loads rate_sel from data bits 1:0 and leaves precomp_sel unchanged. The last write to offset 4 or offset 7 decides the rate.
- R4: A write at offset 4 with data bit 7 set raises soft_rst for exactly one cycle, the cycle after the write. Fields loaded by that same write take effect. A later write with bit 7 clear produces no pulse.
- R5: A write at offset 4 with bit 6 set and bit 7 clear sets low_power and drops clk_en and dsep_en on the next cycle. A later write at offset 4 with bit 6 clear does not leave the mode.
- R6: A read at offset 4, or a read or write at offset 5, clears low_power (and raises clk_en and dsep_en) on the next cycle.
- R7: A soft reset clears low_power. A single write with both bit 6 and bit 7 set leaves low_power at 0.
- R8: Data bit 5 of an offset 4 write has no effect on any output.
- R9: Strobes with bus_cs low, and accesses to offsets other than 4, 5 and 7, change no output. A read at offset 7 changes no output.
- R10: precomp_trk takes trk_value on the cycle after trk_load. A soft reset leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Hardware reset, active low, asynchronous assert |
| bus_cs | input | 1 | Chip select for the controller register window |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 3 | Register offset within the window |
| bus_wdata | input | 8 | Write data |
| trk_load | input | 1 | Configure command supplies a new precompensation start track |
| trk_value | input | 8 | Start track from the configure command |
| rate_sel | output | 2 | Effective data-rate code |
| precomp_sel | output | 3 | Write-precompensation code |
| low_power | output | 1 | Manual low-power mode active |
| soft_rst | output | 1 | One-cycle soft reset pulse to the core |
| clk_en | output | 1 | Controller clock enable |
| dsep_en | output | 1 | Data-separator enable |
| precomp_trk | output | 8 | Track at which precompensation begins |

## Verification
If the rate state is wrong, for example because the two rate registers fail to merge or a soft reset clears the rate, rate_sel is off on the first cycle after the write in question. A stuck or stretched reset bit appears as a soft_rst pulse that is missing, lasts two cycles, or comes back on an unrelated write. A wrong power state is visible at once on clk_en and dsep_en. The cases that matter are a wake access, a combined power-plus-reset write, and a rate write that does not set the power bit. A wrong power state is often hidden until one of these happens, so the bench reads the enables right after each one.

// File: rtl/fdc_rate_pkg.sv
package fdc_rate_pkg;

  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned RATE_W  = 2;
  localparam int unsigned PRE_W   = 3;

  // Field positions inside the rate/power register
  localparam int unsigned RATE_LSB = 0;
  localparam int unsigned PRE_LSB  = 2;
  localparam int unsigned LP_BIT   = 6;
  localparam int unsigned SRST_BIT = 7;

  typedef enum logic [RATE_W-1:0] {
    RATE_500K = 2'b00,
    RATE_300K = 2'b01,
    RATE_250K = 2'b10,
    RATE_1M   = 2'b11
  } rate_e;

  typedef struct packed {
    logic dsr_wr;   // write to rate/power register
    logic ccr_wr;   // write to configuration control register
    logic wake;     // data access or status read
  } bus_evt_t;

endpackage

// File: rtl/fdc_rst_sync.sv
module fdc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/fdc_bus_decode.sv
module fdc_bus_decode
  import fdc_rate_pkg::*;
#(
  parameter int unsigned ADDR_W   = 3,
  parameter logic [ADDR_W-1:0] DSR_OFS  = 3'd4,
  parameter logic [ADDR_W-1:0] DATA_OFS = 3'd5,
  parameter logic [ADDR_W-1:0] CCR_OFS  = 3'd7
) (
  input  logic              cs,
  input  logic              rd,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  output bus_evt_t          evt
);

  logic hit_dsr, hit_data, hit_ccr;

  always_comb begin
    hit_dsr  = cs && (addr == DSR_OFS);
    hit_data = cs && (addr == DATA_OFS);
    hit_ccr  = cs && (addr == CCR_OFS);

    evt.dsr_wr = hit_dsr && wr;
    evt.ccr_wr = hit_ccr && wr;
    // status read shares offset 4; any data-port access also wakes
    evt.wake   = (hit_dsr && rd && !wr) || (hit_data && (rd || wr));
  end

endmodule

// File: rtl/fdc_rate_regs.sv
module fdc_rate_regs
  import fdc_rate_pkg::*;
#(
  parameter logic [RATE_W-1:0] RST_RATE = RATE_250K,
  parameter logic [PRE_W-1:0]  RST_PRE  = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dsr_wr,
  input  logic              ccr_wr,
  input  logic [RATE_W-1:0] wr_rate,
  input  logic [PRE_W-1:0]  wr_pre,
  output logic [RATE_W-1:0] rate_o,
  output logic [PRE_W-1:0]  pre_o
);

  logic [RATE_W-1:0] rate_q, rate_d;
  logic [PRE_W-1:0]  pre_q, pre_d;
  logic              rate_en, pre_en;

  always_comb begin
    rate_en = dsr_wr || ccr_wr;
    pre_en  = dsr_wr;
    rate_d  = wr_rate;
    pre_d   = wr_pre;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rate_q <= RST_RATE;
    end else if (rate_en) begin
      rate_q <= rate_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= RST_PRE;
    end else if (pre_en) begin
      pre_q <= pre_d;
    end
  end

  assign rate_o = rate_q;
  assign pre_o  = pre_q;

endmodule

// File: rtl/fdc_power_ctl.sv
module fdc_power_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic dsr_wr,
  input  logic lp_bit,
  input  logic srst_bit,
  input  logic wake,
  output logic low_power,
  output logic soft_rst,
  output logic clk_en,
  output logic dsep_en
);

  logic lp_q, lp_d;
  logic srst_q, srst_d;

  always_comb begin
    srst_d = dsr_wr && srst_bit;
    lp_d   = lp_q;
    if (srst_d || wake) begin
      lp_d = 1'b0;
    end else if (dsr_wr && lp_bit) begin
      lp_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lp_q   <= 1'b0;
      srst_q <= 1'b0;
    end else begin
      lp_q   <= lp_d;
      srst_q <= srst_d;
    end
  end

  assign low_power = lp_q;
  assign soft_rst  = srst_q;
  assign clk_en    = !lp_q;
  assign dsep_en   = !lp_q;

endmodule

// File: rtl/fdc_precomp_track.sv
module fdc_precomp_track #(
  parameter int unsigned TRK_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [TRK_W-1:0] value,
  output logic [TRK_W-1:0] trk
);

  logic [TRK_W-1:0] trk_q, trk_d;

  always_comb trk_d = value;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    trk_q <= '0;
    else if (load) trk_q <= trk_d;
  end

  assign trk = trk_q;

endmodule

// File: rtl/fdc_rate_ctl.sv
module fdc_rate_ctl
  import fdc_rate_pkg::*;
#(
  parameter int unsigned ADDR_W   = 3,
  parameter int unsigned TRK_W    = 8,
  parameter logic [ADDR_W-1:0] DSR_OFS  = 3'd4,
  parameter logic [ADDR_W-1:0] DATA_OFS = 3'd5,
  parameter logic [ADDR_W-1:0] CCR_OFS  = 3'd7,
  parameter logic [BYTE_W-1:0] RST_DSR  = 8'h02
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_cs,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BYTE_W-1:0] bus_wdata,
  input  logic              trk_load,
  input  logic [TRK_W-1:0]  trk_value,
  output logic [RATE_W-1:0] rate_sel,
  output logic [PRE_W-1:0]  precomp_sel,
  output logic              low_power,
  output logic              soft_rst,
  output logic              clk_en,
  output logic              dsep_en,
  output logic [TRK_W-1:0]  precomp_trk
);

  localparam logic [RATE_W-1:0] RST_RATE = RST_DSR[RATE_LSB +: RATE_W];
  localparam logic [PRE_W-1:0]  RST_PRE  = RST_DSR[PRE_LSB +: PRE_W];

  logic     rst_n_i;
  bus_evt_t evt;

  fdc_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  fdc_bus_decode #(
    .ADDR_W   (ADDR_W),
    .DSR_OFS  (DSR_OFS),
    .DATA_OFS (DATA_OFS),
    .CCR_OFS  (CCR_OFS)
  ) u_dec (
    .cs   (bus_cs),
    .rd   (bus_rd),
    .wr   (bus_wr),
    .addr (bus_addr),
    .evt  (evt)
  );

  fdc_rate_regs #(
    .RST_RATE (RST_RATE),
    .RST_PRE  (RST_PRE)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_n_i),
    .dsr_wr  (evt.dsr_wr),
    .ccr_wr  (evt.ccr_wr),
    .wr_rate (bus_wdata[RATE_LSB +: RATE_W]),
    .wr_pre  (bus_wdata[PRE_LSB +: PRE_W]),
    .rate_o  (rate_sel),
    .pre_o   (precomp_sel)
  );

  fdc_power_ctl u_pwr (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .dsr_wr    (evt.dsr_wr),
    .lp_bit    (bus_wdata[LP_BIT]),
    .srst_bit  (bus_wdata[SRST_BIT]),
    .wake      (evt.wake),
    .low_power (low_power),
    .soft_rst  (soft_rst),
    .clk_en    (clk_en),
    .dsep_en   (dsep_en)
  );

  fdc_precomp_track #(.TRK_W(TRK_W)) u_trk (
    .clk   (clk),
    .rst_n (rst_n_i),
    .load  (trk_load),
    .value (trk_value),
    .trk   (precomp_trk)
  );

endmodule

// File: rtl/fdc_rate_ctl_chk.sv
module fdc_rate_ctl_chk #(
  parameter int unsigned ADDR_W   = 3,
  parameter int unsigned TRK_W    = 8,
  parameter logic [ADDR_W-1:0] DSR_OFS  = 3'd4,
  parameter logic [ADDR_W-1:0] DATA_OFS = 3'd5,
  parameter logic [ADDR_W-1:0] CCR_OFS  = 3'd7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_cs,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [7:0]        bus_wdata,
  input logic              trk_load,
  input logic [1:0]        rate_sel,
  input logic [2:0]        precomp_sel,
  input logic              low_power,
  input logic              soft_rst,
  input logic [TRK_W-1:0]  precomp_trk
);

  logic w_dsr, w_ccr, wake_acc;
  assign w_dsr    = bus_cs && bus_wr && (bus_addr == DSR_OFS);
  assign w_ccr    = bus_cs && bus_wr && (bus_addr == CCR_OFS);
  assign wake_acc = bus_cs && ((bus_rd && !bus_wr && bus_addr == DSR_OFS) ||
                               ((bus_rd || bus_wr) && bus_addr == DATA_OFS));

  AST_DSR_RATE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    w_dsr |=> (rate_sel == $past(bus_wdata[1:0])) && (precomp_sel == $past(bus_wdata[4:2]))); // R2

  AST_CCR_KEEPS_PRE: assert property (@(posedge clk) disable iff (!rst_n)
    w_ccr |=> (rate_sel == $past(bus_wdata[1:0])) && $stable(precomp_sel)); // R3

  AST_SRST_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> !soft_rst); // R4

  AST_SRST_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(soft_rst) |-> $past(w_dsr && bus_wdata[7])); // R4

  AST_LP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(low_power) |-> $past(w_dsr && bus_wdata[6] && !bus_wdata[7])); // R5

  AST_LP_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (low_power && wake_acc) |=> !low_power); // R6

  AST_SRST_CLEARS_LP: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |-> !low_power); // R7

  AST_NO_STRAY_RATE: assert property (@(posedge clk) disable iff (!rst_n)
    !(w_dsr || w_ccr) |=> $stable(rate_sel) && $stable(precomp_sel)); // R9

  AST_TRK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !trk_load |=> $stable(precomp_trk)); // R10

endmodule

bind fdc_rate_ctl fdc_rate_ctl_chk #(
  .ADDR_W   (ADDR_W),
  .TRK_W    (TRK_W),
  .DSR_OFS  (DSR_OFS),
  .DATA_OFS (DATA_OFS),
  .CCR_OFS  (CCR_OFS)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_cs      (bus_cs),
  .bus_rd      (bus_rd),
  .bus_wr      (bus_wr),
  .bus_addr    (bus_addr),
  .bus_wdata   (bus_wdata),
  .trk_load    (trk_load),
  .rate_sel    (rate_sel),
  .precomp_sel (precomp_sel),
  .low_power   (low_power),
  .soft_rst    (soft_rst),
  .precomp_trk (precomp_trk)
);

// File: tb/fdc_rate_ctl_test.sv
`timescale 1ns/1ps
module fdc_rate_ctl_test;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       bus_cs, bus_rd, bus_wr;
  logic [2:0] bus_addr;
  logic [7:0] bus_wdata;
  logic       trk_load;
  logic [7:0] trk_value;
  logic [1:0] rate_sel;
  logic [2:0] precomp_sel;
  logic       low_power, soft_rst, clk_en, dsep_en;
  logic [7:0] precomp_trk;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  fdc_rate_ctl uut (
    .clk(clk), .rst_n(rst_n), .bus_cs(bus_cs), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .trk_load(trk_load),
    .trk_value(trk_value), .rate_sel(rate_sel), .precomp_sel(precomp_sel),
    .low_power(low_power), .soft_rst(soft_rst), .clk_en(clk_en),
    .dsep_en(dsep_en), .precomp_trk(precomp_trk)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Full output snapshot: rate, precomp, low power, pulse
  task automatic expect_state(input string req, input logic [1:0] r,
                              input logic [2:0] p, input logic lp, input logic sr);
    check(req, "rate_sel", rate_sel, r);
    check(req, "precomp_sel", precomp_sel, p);
    check(req, "low_power", low_power, lp);
    check(req, "clk_en", clk_en, !lp);
    check(req, "dsep_en", dsep_en, !lp);
    check(req, "soft_rst", soft_rst, sr);
  endtask

  // One bus cycle; returns at the next falling edge, after the capturing edge
  task automatic bus_op(input logic cs, input logic rd, input logic wr,
                        input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_cs = cs; bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_cs = 1'b0; bus_rd = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    bus_cs = 1'b0; bus_rd = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    trk_load = 1'b0; trk_value = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    expect_state("R1", 2'b10, 3'd0, 1'b0, 1'b0);
    check("R1", "precomp_trk", precomp_trk, 8'h00);
  endtask

  task automatic t_dsr_rates();
    bus_op(1, 0, 1, 3'd4, 8'h00); expect_state("R2", 2'b00, 3'd0, 0, 0);
    bus_op(1, 0, 1, 3'd4, 8'h05); expect_state("R2", 2'b01, 3'd1, 0, 0);
    bus_op(1, 0, 1, 3'd4, 8'h1F); expect_state("R2", 2'b11, 3'd7, 0, 0);
    bus_op(1, 0, 1, 3'd4, 8'h12); expect_state("R2", 2'b10, 3'd4, 0, 0);
  endtask

  task automatic t_ccr_shared();
    bus_op(1, 0, 1, 3'd4, 8'h0C); expect_state("R3", 2'b00, 3'd3, 0, 0);
    bus_op(1, 0, 1, 3'd7, 8'h03); expect_state("R3", 2'b11, 3'd3, 0, 0);
    bus_op(1, 0, 1, 3'd7, 8'hFD); expect_state("R3", 2'b01, 3'd3, 0, 0);
    bus_op(1, 0, 1, 3'd4, 8'h0E); expect_state("R3", 2'b10, 3'd3, 0, 0);
  endtask

  task automatic t_soft_reset();
    bus_op(1, 0, 1, 3'd4, 8'h96); expect_state("R4", 2'b10, 3'd5, 0, 1);
    idle();                        expect_state("R4", 2'b10, 3'd5, 0, 0);
    bus_op(1, 0, 1, 3'd4, 8'h16); expect_state("R4", 2'b10, 3'd5, 0, 0);
  endtask

  task automatic t_low_power();
    bus_op(1, 0, 1, 3'd4, 8'h42); expect_state("R5", 2'b10, 3'd0, 1, 0);
    bus_op(1, 0, 1, 3'd4, 8'h01); expect_state("R5", 2'b01, 3'd0, 1, 0);
    bus_op(1, 1, 0, 3'd4, 8'h00); expect_state("R6", 2'b01, 3'd0, 0, 0);
    bus_op(1, 0, 1, 3'd4, 8'h42); check("R5", "low_power", low_power, 1'b1);
    bus_op(1, 1, 0, 3'd5, 8'h00); expect_state("R6", 2'b10, 3'd0, 0, 0);
    bus_op(1, 0, 1, 3'd4, 8'h42); check("R5", "low_power", low_power, 1'b1);
    bus_op(1, 0, 1, 3'd5, 8'hAA); expect_state("R6", 2'b10, 3'd0, 0, 0);
    bus_op(1, 0, 1, 3'd4, 8'h42);
    bus_op(1, 0, 1, 3'd4, 8'h82); expect_state("R7", 2'b10, 3'd0, 0, 1);
    bus_op(1, 0, 1, 3'd4, 8'hC2); expect_state("R7", 2'b10, 3'd0, 0, 1);
    idle();                        expect_state("R7", 2'b10, 3'd0, 0, 0);
  endtask

  task automatic t_reserved_bit();
    bus_op(1, 0, 1, 3'd4, 8'h2D); expect_state("R8", 2'b01, 3'd3, 0, 0);
    bus_op(1, 0, 1, 3'd4, 8'h30); expect_state("R8", 2'b00, 3'd4, 0, 0);
  endtask

  task automatic t_ignored();
    bus_op(1, 0, 1, 3'd4, 8'h09); expect_state("R9", 2'b01, 3'd2, 0, 0);
    bus_op(0, 0, 1, 3'd4, 8'hFF); expect_state("R9", 2'b01, 3'd2, 0, 0);
    bus_op(0, 0, 1, 3'd7, 8'hFE); expect_state("R9", 2'b01, 3'd2, 0, 0);
    bus_op(1, 0, 1, 3'd2, 8'hFF); expect_state("R9", 2'b01, 3'd2, 0, 0);
    bus_op(1, 1, 0, 3'd7, 8'hFF); expect_state("R9", 2'b01, 3'd2, 0, 0);
    bus_op(1, 0, 1, 3'd4, 8'h49); expect_state("R9", 2'b01, 3'd2, 1, 0);
    bus_op(0, 1, 0, 3'd5, 8'h00); expect_state("R9", 2'b01, 3'd2, 1, 0);
    bus_op(0, 1, 0, 3'd4, 8'h00); expect_state("R9", 2'b01, 3'd2, 1, 0);
    bus_op(1, 1, 0, 3'd3, 8'h00); expect_state("R9", 2'b01, 3'd2, 1, 0);
    bus_op(1, 1, 0, 3'd4, 8'h00); expect_state("R6", 2'b01, 3'd2, 0, 0);
  endtask

  task automatic t_track();
    @(negedge clk); trk_load = 1'b1; trk_value = 8'h27;
    @(negedge clk); trk_load = 1'b0; trk_value = 8'hFF;
    check("R10", "precomp_trk load", precomp_trk, 8'h27);
    idle();
    check("R10", "precomp_trk hold", precomp_trk, 8'h27);
    bus_op(1, 0, 1, 3'd4, 8'h80);
    check("R10", "precomp_trk after soft reset", precomp_trk, 8'h27);
    expect_state("R4", 2'b00, 3'd0, 0, 1);
    do_reset();
    check("R10", "precomp_trk after hard reset", precomp_trk, 8'h00);
    check("R1", "rate_sel after hard reset", rate_sel, 2'b10);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    rst_n = 1'b0;
    bus_cs = 1'b0; bus_rd = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    trk_load = 1'b0; trk_value = '0;
    t_reset();
    t_dsr_rates();
    t_ccr_shared();
    t_soft_reset();
    t_low_power();
    t_reserved_bit();
    t_ignored();
    t_track();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule